// File: doc/BRIEF.md
# Single-Step Trap Pending Controller

This block decides, instruction by instruction, when a single-step debug trap and a monitor-trap-flag (MTF) exit become pending around the instructions that enter and leave a protected execution region. Each retire event carries a class code and is sampled together with the current trap flag, the guest-mode flag and the MTF control bit. The block records whether the region was entered in opt-out mode. If it was, no trap is raised inside the region. The traps are then deferred to the boundary after the exit instruction, using the trap flag and MTF enable that were captured when the region was entered.

Faults, VM exits and high-priority events (system-management interrupt, INIT, machine check) shape the result. A fault suppresses the debug trap but still lets the MTF exit pend. A VM exit discards the MTF exit. A high-priority event wins over both pending traps.

Each pending indication holds until it is acknowledged. The handler-select outputs present the single-step trap ahead of the MTF exit.

Top module: `sstep_trap_ctrl`

## Requirements
- R1: After reset, `ss_pending`, `mtf_pending`, `tf_restore`, `sel_ss_hdl`, `sel_mtf_hdl` and `sel_hi_hdl` are all 0.
- R2: A retire of class 0 (ordinary) or 3 (report/key leaf) outside an opt-out region, with `trap_flag`=1 and no fault, makes `ss_pending` 1 in the cycle after the retire.
- R3: A retire of class 0 or 3 outside an opt-out region, with `guest_mode`=1 and `mtf_ctrl`=1, makes `mtf_pending` 1 in the following cycle. This holds whether or not `fault_evt` is set.
- R4: A retire with `fault_evt`=1 never sets `ss_pending`, whatever the trap flag or region state.
- R5: After a retire of class 1 (entry) with `optout_entry`=1, retires of class 0 and 3 set neither pending output until the region ends.
- R6: A retire of class 2 (exit) ending an opt-out region sets `ss_pending` from the trap flag captured at entry. It sets `mtf_pending` from (`guest_mode` AND `mtf_ctrl`) captured at entry. Outside such a region, an exit uses the current values.
- R7: In the cycle after an exit retire, `tf_restore` equals the trap flag captured at the last entry if a region was open, and otherwise the current `trap_flag`. Other retires leave it unchanged.
- R8: `vmexit_evt` clears `mtf_pending` in the next cycle and blocks an MTF exit armed in the same cycle.
- R9: Any of `smi_evt`, `init_evt` or `mce_evt` clears both pending outputs, blocks same-cycle arming, and makes `sel_hi_hdl` 1 for the next cycle.
- R10: `sel_ss_hdl` equals `ss_pending`. `sel_mtf_hdl` is 1 only when `mtf_pending`=1 and `ss_pending`=0. `mtf_ack` has no effect while `ss_pending` is 1.
- R11: A pending output stays 1 until its acknowledge is pulsed. The acknowledge clears it in the next cycle, except that a new arming in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| retire_cls | input | 2 | Class: 0 ordinary, 1 entry, 2 exit, 3 report/key leaf |
| trap_flag | input | 1 | Current single-step trap flag |
| guest_mode | input | 1 | Executing as a guest |
| mtf_ctrl | input | 1 | Monitor-trap-flag control bit |
| optout_entry | input | 1 | Entry is opt-out (debug masked) |
| fault_evt | input | 1 | Retiring instruction faulted; fault delivered |
| vmexit_evt | input | 1 | Another VM exit occurred |
| smi_evt | input | 1 | System-management interrupt at this boundary |
| init_evt | input | 1 | INIT at this boundary |
| mce_evt | input | 1 | Machine check at this boundary |
| ss_ack | input | 1 | Single-step trap taken |
| mtf_ack | input | 1 | MTF exit taken |
| ss_pending | output | 1 | Single-step trap pending |
| mtf_pending | output | 1 | MTF exit pending |
| tf_restore | output | 1 | Trap flag value after the last exit |
| sel_ss_hdl | output | 1 | Select the single-step handler |
| sel_mtf_hdl | output | 1 | Select the MTF handler |
| sel_hi_hdl | output | 1 | Select the high-priority handler (one cycle) |

## Verification
The bench sweeps every combination of region context (none, normal, opt-out), the flags captured at entry, the retire class and the current trap, guest, MTF and fault inputs. Each result is compared with a model computed in the bench.

The sweep targets designs that trap inside an opt-out region, or that use the current flags instead of the captured ones at exit. It also targets designs that let a fault raise a debug trap, or that cancel the MTF exit on a fault.

Directed sequences check the ordering between the two traps. A design that presents the MTF exit first, or honours `mtf_ack` while a step trap is pending, shows the wrong handler select. The sequences also check that pending outputs hold across idle cycles, that a VM exit drops only the MTF exit, and that each high-priority source clears both pending outputs.

// File: rtl/sstep_pkg.sv
package sstep_pkg;
  localparam int CLS_W = 2;
  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_ENTER  = 2'd1,
    CLS_EXIT   = 2'd2,
    CLS_REPORT = 2'd3
  } retire_cls_e;

  localparam int NUM_PEND = 2;
  localparam int PEND_SS  = 0;
  localparam int PEND_MTF = 1;

  // single-step arming decision for one retire boundary
  function automatic logic ss_arm_f(
    input logic is_step, input logic is_exit, input logic masked,
    input logic cur_tf, input logic kept_tf, input logic fault, input logic hi);
    logic src;
    src = is_exit ? (masked ? kept_tf : cur_tf) : (is_step && !masked && cur_tf);
    return src && !fault && !hi;
  endfunction

  // MTF arming decision; a fault does not suppress it
  function automatic logic mtf_arm_f(
    input logic is_step, input logic is_exit, input logic masked,
    input logic cur_en, input logic kept_en, input logic vmx, input logic hi);
    logic src;
    src = is_exit ? (masked ? kept_en : cur_en) : (is_step && !masked && cur_en);
    return src && !vmx && !hi;
  endfunction
endpackage

// File: rtl/sstep_region_tracker.sv
module sstep_region_tracker
  import sstep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enter_stb,
  input  logic exit_stb,
  input  logic optout_in,
  input  logic tf_in,
  input  logic mtf_en_in,
  output logic in_region,
  output logic region_optout,
  output logic kept_tf,
  output logic kept_mtf,
  output logic tf_restore
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_region     <= 1'b0;
      region_optout <= 1'b0;
      kept_tf       <= 1'b0;
      kept_mtf      <= 1'b0;
      tf_restore    <= 1'b0;
    end else if (enter_stb) begin
      in_region     <= 1'b1;
      region_optout <= optout_in;
      kept_tf       <= tf_in;
      kept_mtf      <= mtf_en_in;
    end else if (exit_stb) begin
      in_region     <= 1'b0;
      region_optout <= 1'b0;
      tf_restore    <= in_region ? kept_tf : tf_in;
    end
  end
endmodule

// File: rtl/sstep_arm_logic.sv
module sstep_arm_logic
  import sstep_pkg::*;
(
  input  logic             retire_vld,
  input  logic [CLS_W-1:0] retire_cls,
  input  logic             masked,
  input  logic             cur_tf,
  input  logic             cur_mtf_en,
  input  logic             kept_tf,
  input  logic             kept_mtf,
  input  logic             fault,
  input  logic             vmx,
  input  logic             hi,
  output logic             enter_stb,
  output logic             exit_stb,
  output logic             arm_ss,
  output logic             arm_mtf
);
  logic is_step;
  always_comb begin
    enter_stb = retire_vld && (retire_cls == CLS_ENTER);
    exit_stb  = retire_vld && (retire_cls == CLS_EXIT);
    is_step   = retire_vld && ((retire_cls == CLS_PLAIN) || (retire_cls == CLS_REPORT));
    arm_ss    = ss_arm_f(is_step, exit_stb, masked, cur_tf, kept_tf, fault, hi);
    arm_mtf   = mtf_arm_f(is_step, exit_stb, masked, cur_mtf_en, kept_mtf, vmx, hi);
  end
endmodule

// File: rtl/sstep_pend_cell.sv
module sstep_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic cancel_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)        pend_o <= 1'b0;
    else if (cancel_i) pend_o <= 1'b0;
    else if (set_i)    pend_o <= 1'b1;
    else if (ack_i)    pend_o <= 1'b0;
  end
endmodule

// File: rtl/sstep_trap_ctrl.sv
module sstep_trap_ctrl
  import sstep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_vld,
  input  logic [CLS_W-1:0] retire_cls,
  input  logic             trap_flag,
  input  logic             guest_mode,
  input  logic             mtf_ctrl,
  input  logic             optout_entry,
  input  logic             fault_evt,
  input  logic             vmexit_evt,
  input  logic             smi_evt,
  input  logic             init_evt,
  input  logic             mce_evt,
  input  logic             ss_ack,
  input  logic             mtf_ack,
  output logic             ss_pending,
  output logic             mtf_pending,
  output logic             tf_restore,
  output logic             sel_ss_hdl,
  output logic             sel_mtf_hdl,
  output logic             sel_hi_hdl
);
  // named internal events (observed by the checker)
  logic in_region, region_optout, kept_tf, kept_mtf;
  logic masked, hi_evt, cur_mtf_en;
  logic enter_stb, exit_stb, arm_ss, arm_mtf;
  logic [NUM_PEND-1:0] pend_set, pend_ack, pend_cancel, pend_q;

  assign hi_evt     = smi_evt | init_evt | mce_evt;
  assign cur_mtf_en = guest_mode & mtf_ctrl;
  assign masked     = in_region & region_optout;

  sstep_region_tracker u_region (
    .clk(clk), .rst_n(rst_n), .enter_stb(enter_stb), .exit_stb(exit_stb),
    .optout_in(optout_entry), .tf_in(trap_flag), .mtf_en_in(cur_mtf_en),
    .in_region(in_region), .region_optout(region_optout),
    .kept_tf(kept_tf), .kept_mtf(kept_mtf), .tf_restore(tf_restore)
  );

  sstep_arm_logic u_arm (
    .retire_vld(retire_vld), .retire_cls(retire_cls), .masked(masked),
    .cur_tf(trap_flag), .cur_mtf_en(cur_mtf_en), .kept_tf(kept_tf),
    .kept_mtf(kept_mtf), .fault(fault_evt), .vmx(vmexit_evt), .hi(hi_evt),
    .enter_stb(enter_stb), .exit_stb(exit_stb), .arm_ss(arm_ss), .arm_mtf(arm_mtf)
  );

  assign pend_set[PEND_SS]     = arm_ss;
  assign pend_set[PEND_MTF]    = arm_mtf;
  assign pend_ack[PEND_SS]     = ss_ack;
  assign pend_ack[PEND_MTF]    = mtf_ack & ~pend_q[PEND_SS];
  assign pend_cancel[PEND_SS]  = hi_evt;
  assign pend_cancel[PEND_MTF] = hi_evt | vmexit_evt;

  for (genvar gi = 0; gi < NUM_PEND; gi++) begin : g_pend
    sstep_pend_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(pend_set[gi]), .ack_i(pend_ack[gi]),
      .cancel_i(pend_cancel[gi]), .pend_o(pend_q[gi])
    );
  end

  assign ss_pending  = pend_q[PEND_SS];
  assign mtf_pending = pend_q[PEND_MTF];
  assign sel_ss_hdl  = pend_q[PEND_SS];
  assign sel_mtf_hdl = pend_q[PEND_MTF] & ~pend_q[PEND_SS];

  always_ff @(posedge clk) begin
    if (!rst_n) sel_hi_hdl <= 1'b0;
    else        sel_hi_hdl <= hi_evt;
  end
endmodule

// File: rtl/sstep_trap_ctrl_chk.sv
module sstep_trap_ctrl_chk
  import sstep_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             retire_vld,
  input logic [CLS_W-1:0] retire_cls,
  input logic             fault_evt,
  input logic             vmexit_evt,
  input logic             hi_evt,
  input logic             masked,
  input logic             in_region,
  input logic             kept_tf,
  input logic             arm_ss,
  input logic             mtf_ack,
  input logic             ss_ack,
  input logic             ss_pending,
  input logic             mtf_pending,
  input logic             tf_restore,
  input logic             sel_ss_hdl,
  input logic             sel_mtf_hdl,
  input logic             sel_hi_hdl
);
  AST_FAULT_NO_SS: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && fault_evt && !ss_pending) |=> !ss_pending); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && masked && (retire_cls == CLS_PLAIN || retire_cls == CLS_REPORT)
     && !ss_pending && !mtf_pending && !vmexit_evt) |=> (!ss_pending && !mtf_pending)); // R5
  AST_EXIT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && retire_cls == CLS_EXIT && in_region) |=> (tf_restore == $past(kept_tf))); // R7
  AST_VMEXIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    vmexit_evt |=> !mtf_pending); // R8
  AST_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hi_evt |=> (sel_hi_hdl && !ss_pending && !mtf_pending)); // R9
  AST_SEL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ss_hdl, sel_mtf_hdl}) && (sel_mtf_hdl -> !ss_pending)); // R10
  AST_MTF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mtf_pending && ss_pending && mtf_ack && !hi_evt && !vmexit_evt) |=> mtf_pending); // R10
  AST_SS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_pending && ss_ack && !arm_ss && !hi_evt) |=> !ss_pending); // R11
endmodule

bind sstep_trap_ctrl sstep_trap_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_cls(retire_cls),
  .fault_evt(fault_evt), .vmexit_evt(vmexit_evt), .hi_evt(hi_evt),
  .masked(masked), .in_region(in_region), .kept_tf(kept_tf), .arm_ss(arm_ss),
  .mtf_ack(mtf_ack), .ss_ack(ss_ack), .ss_pending(ss_pending),
  .mtf_pending(mtf_pending), .tf_restore(tf_restore), .sel_ss_hdl(sel_ss_hdl),
  .sel_mtf_hdl(sel_mtf_hdl), .sel_hi_hdl(sel_hi_hdl)
);

// File: tb/tb_sstep_trap_ctrl.sv
`timescale 1ns/1ps
module tb_sstep_trap_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_vld = 0, trap_flag = 0, guest_mode = 0, mtf_ctrl = 0, optout_entry = 0;
  logic fault_evt = 0, vmexit_evt = 0, smi_evt = 0, init_evt = 0, mce_evt = 0;
  logic ss_ack = 0, mtf_ack = 0;
  logic [1:0] retire_cls = 2'd0;
  logic ss_pending, mtf_pending, tf_restore, sel_ss_hdl, sel_mtf_hdl, sel_hi_hdl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sstep_trap_ctrl dut (.*);

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {ss,mtf,tfr,sss,ssm,shi}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {ss_pending, mtf_pending, tf_restore, sel_ss_hdl, sel_mtf_hdl, sel_hi_hdl};
  endfunction

  task automatic clear_in();
    retire_vld = 0; retire_cls = 0; trap_flag = 0; guest_mode = 0; mtf_ctrl = 0;
    optout_entry = 0; fault_evt = 0; vmexit_evt = 0; smi_evt = 0; init_evt = 0;
    mce_evt = 0; ss_ack = 0; mtf_ack = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); clear_in(); rst_n = 0;
    @(posedge clk); @(posedge clk); #1; rst_n = 1;
  endtask

  // one retire, inputs held over one rising edge, outputs sampled 1ns after
  task automatic retire(input logic [1:0] c, input logic tf, input logic g,
                        input logic m, input logic oo, input logic f);
    @(negedge clk);
    retire_vld = 1; retire_cls = c; trap_flag = tf; guest_mode = g;
    mtf_ctrl = m; optout_entry = oo; fault_evt = f;
    @(posedge clk); #1; clear_in();
  endtask

  task automatic pulse(input logic a_ss, input logic a_mtf, input logic vx,
                       input logic s, input logic i, input logic mc);
    @(negedge clk);
    ss_ack = a_ss; mtf_ack = a_mtf; vmexit_evt = vx; smi_evt = s; init_evt = i; mce_evt = mc;
    @(posedge clk); #1; clear_in();
  endtask

  initial begin
    logic ess, emtf, etfr;
    do_reset();
    chk("R1", outs(), 6'b000000);

    // sweep: context x entry flags x class x current flags x fault
    for (int ctx = 0; ctx < 3; ctx++)
      for (int etf = 0; etf < 2; etf++)
        for (int egm = 0; egm < 2; egm++)
          for (int ci = 0; ci < 3; ci++)
            for (int v = 0; v < 16; v++) begin
              logic [1:0] c;
              logic tf, g, m, f;
              c  = (ci == 0) ? 2'd0 : (ci == 1) ? 2'd3 : 2'd2;
              tf = v[0]; g = v[1]; m = v[2]; f = v[3];
              if (ctx == 0 && (etf != 0 || egm != 0)) continue;
              do_reset();
              if (ctx != 0) retire(2'd1, etf[0], egm[0], 1'b1, ctx == 2, 1'b0);
              retire(c, tf, g, m, 1'b0, f);
              if (c == 2'd2) begin
                ess  = ((ctx == 2) ? etf[0] : tf) & ~f;
                emtf = (ctx == 2) ? egm[0] : (g & m);
                etfr = (ctx != 0) ? etf[0] : tf;
              end else begin
                ess  = (ctx != 2) & tf & ~f;
                emtf = (ctx != 2) & g & m;
                etfr = 1'b0;
              end
              // R2 R3 R4 R5 R6 R7 R10
              chk((c == 2'd2) ? "R6/R7" : (ctx == 2) ? "R5" : f ? "R4/R3" : "R2/R3",
                  outs(), {ess, emtf, etfr, ess, emtf & ~ess, 1'b0});
            end

    // R10 R11: both pending, hold, mtf_ack ignored while ss pending
    do_reset();
    retire(2'd0, 1, 1, 1, 0, 0);
    repeat (5) @(posedge clk); #1;
    chk("R11 hold", outs(), 6'b110100);
    pulse(0, 1, 0, 0, 0, 0);
    chk("R10 mtf_ack ignored", outs(), 6'b110100);
    pulse(1, 0, 0, 0, 0, 0);
    chk("R10 mtf selected", outs(), 6'b010010);
    pulse(0, 1, 0, 0, 0, 0);
    chk("R11 mtf ack", outs(), 6'b000000);

    // R11: arming in same cycle as ack keeps it set
    do_reset();
    retire(2'd3, 1, 0, 0, 0, 0);
    @(negedge clk);
    retire_vld = 1; retire_cls = 2'd0; trap_flag = 1; ss_ack = 1;
    @(posedge clk); #1; clear_in();
    chk("R11 set beats ack", outs(), 6'b100100);

    // R8: vmexit drops mtf, keeps ss
    do_reset();
    retire(2'd0, 1, 1, 1, 0, 0);
    pulse(0, 0, 1, 0, 0, 0);
    chk("R8 drop", outs(), 6'b100100);
    do_reset();
    @(negedge clk);
    retire_vld = 1; retire_cls = 2'd0; guest_mode = 1; mtf_ctrl = 1; vmexit_evt = 1;
    @(posedge clk); #1; clear_in();
    chk("R8 block", outs(), 6'b000000);

    // R9: each high-priority source
    for (int s = 0; s < 3; s++) begin
      do_reset();
      retire(2'd0, 1, 1, 1, 0, 0);
      pulse(0, 0, 0, s == 0, s == 1, s == 2);
      chk("R9 cancel", outs(), 6'b000001);
      @(posedge clk); #1;
      chk("R9 one cycle", outs(), 6'b000000);
    end
    do_reset();
    @(negedge clk);
    retire_vld = 1; retire_cls = 2'd0; trap_flag = 1; guest_mode = 1; mtf_ctrl = 1; smi_evt = 1;
    @(posedge clk); #1; clear_in();
    chk("R9 block", outs(), 6'b000001);

    // R7: non-exit retire leaves tf_restore unchanged
    do_reset();
    retire(2'd1, 1, 0, 0, 1, 0);
    retire(2'd2, 0, 0, 0, 0, 0);
    pulse(1, 0, 0, 0, 0, 0);
    retire(2'd0, 0, 0, 0, 0, 0);
    chk("R7 held", outs(), 6'b001000);

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule